// File: doc/BRIEF.md
# Signed Multichannel Time Interval Counter

This block measures, on several channels at once, how far each channel's hit edge lies from a single shared reference edge. Both edges are stamped against one free-running timebase that counts whole clock ticks. The timebase starts on the first edge that the block accepts. Each channel stores its interval as a signed two's-complement word. A hit that comes later than the reference gives a positive value and a hit that comes earlier gives a negative value. The same logic therefore serves a reference used as a start and a reference used as a stop.

Every result becomes readable one clock after the later of its two edges, so no conversion phase follows the event. Separate veto levels block the hit group and the reference. An end-of-window strobe freezes the capture. A synchronous clear empties every channel and drops the busy flag. One LSB of a result is one clock tick.

Top module: `signed_interval_counter`

## Requirements
- R1: When a channel's hit rising edge is sampled D clock edges after the reference rising edge (0 < D ≤ 2^MAG_W−1), the channel data reads +D and its valid bit is 1.
- R2: When the hit is sampled D edges before the reference (0 < D ≤ 2^MAG_W−1), the data reads −D in (MAG_W+1)-bit two's complement and valid is 1.
- R3: A hit sampled on the same edge as the reference gives data 0 with valid 1.
- R4: While hitVeto is high, rising edges on every hit input are ignored. While refVeto is high, reference rising edges are ignored. A vetoed edge neither sets busy nor moves any result.
- R5: A channel that lacks either an accepted hit or an accepted reference reads data 0 with valid 0.
- R6: Only the first accepted hit edge of a channel and the first accepted reference edge count until the next clear. Once a valid bit is high, it stays high until a clear.
- R7: From the edge where windowEnd is sampled high until the next clear, hit and reference edges are ignored.
- R8: busy goes high on the clock edge that accepts the first hit or reference edge and stays high until a clear.
- R9: On the edge where clearIn is sampled high, all data words and valid bits become 0 and busy becomes 0.
- R10: If the interval magnitude exceeds 2^MAG_W−1, the channel data saturates to +(2^MAG_W−1) or −(2^MAG_W−1) according to the sign, and valid stays 0.
- R11: A result appears on the clock edge after the edge that accepts the later of its two input edges. It is not visible on the accepting edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; one tick is one LSB |
| rstN | input | 1 | Asynchronous active-low reset |
| hitIn | input | NUM_CH | Per-channel hit strobes, synchronous to clk |
| refIn | input | 1 | Shared reference strobe |
| hitVeto | input | 1 | Blocks all hit inputs while high |
| refVeto | input | 1 | Blocks the reference input while high |
| windowEnd | input | 1 | Closes the capture window until clear |
| clearIn | input | 1 | Synchronous clear of all channels and busy |
| dataOut | output | NUM_CH*(MAG_W+1) | Packed signed intervals, channel 0 in the low bits |
| validOut | output | NUM_CH | Per-channel result valid |
| busy | output | 1 | Set by the first accepted edge, held until clear |

## Verification
The bench keeps eight channels but reduces MAG_W to 6. The limit then drops to ±63 ticks, and the saturation boundary on both sides (±63 valid, ±64 and beyond saturated) can be reached within an 80-cycle window. The timebase gets 8 bits at that width, so every window stays well below the counter's saturation point. The 7-bit results are compared bit for bit.

// File: rtl/tic_pkg.sv
package tic_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic clearAll;
    logic refTake;
  } ctrlStrobe_t;
endpackage

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic              refIn,
  input  logic              hitVeto,
  input  logic              refVeto,
  input  logic              windowEnd,
  input  logic              clearIn,
  output ctrlStrobe_t       strobe,
  output logic [NUM_CH-1:0] hitTake,
  output logic [TS_W-1:0]   stamp,
  output logic              busy
);
  localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

  logic [NUM_CH-1:0] hitPrev, hitDone;
  logic              refPrev, refDone, winClosed, running;
  logic [TS_W-1:0]   tbCnt;
  logic              windowOpen, refTake, anyTake;

  always_comb begin
    windowOpen = !clearIn && !windowEnd && !winClosed;
    hitTake    = hitIn & ~hitPrev & ~hitDone & {NUM_CH{windowOpen && !hitVeto}};
    refTake    = refIn && !refPrev && !refDone && windowOpen && !refVeto;
    anyTake    = (|hitTake) || refTake;
    stamp      = running ? tbCnt : '0;
    strobe.clearAll = clearIn;
    strobe.refTake  = refTake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitPrev   <= '0;
      refPrev   <= 1'b0;
      hitDone   <= '0;
      refDone   <= 1'b0;
      winClosed <= 1'b0;
      running   <= 1'b0;
      tbCnt     <= '0;
      busy      <= 1'b0;
    end else begin
      hitPrev <= hitIn;
      refPrev <= refIn;
      if (clearIn) begin
        hitDone   <= '0;
        refDone   <= 1'b0;
        winClosed <= 1'b0;
        running   <= 1'b0;
        tbCnt     <= '0;
        busy      <= 1'b0;
      end else begin
        hitDone <= hitDone | hitTake;
        if (refTake)   refDone   <= 1'b1;
        if (windowEnd) winClosed <= 1'b1;
        if (anyTake) begin
          running <= 1'b1;
          busy    <= 1'b1;
        end
        if ((running || anyTake) && stamp != TS_MAX) tbCnt <= stamp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tic_datapath.sv
module tic_datapath
  import tic_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAG_W  = 23,
  parameter int TS_W   = 25
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic [NUM_CH-1:0]            hitTake,
  input  logic [TS_W-1:0]              stamp,
  output logic [NUM_CH*(MAG_W+1)-1:0]  dataOut,
  output logic [NUM_CH-1:0]            validOut
);
  localparam int RES_W  = MAG_W + 1;
  localparam int DIFF_W = TS_W + 1;
  localparam logic [TS_W-1:0]          TS_MAX  = {TS_W{1'b1}};
  localparam logic signed [DIFF_W-1:0] LIM     = DIFF_W'((2 ** MAG_W) - 1);
  localparam logic [RES_W-1:0]         POS_SAT = {1'b0, {MAG_W{1'b1}}};
  localparam logic [RES_W-1:0]         NEG_SAT = {1'b1, {(MAG_W-1){1'b0}}, 1'b1};

  logic [TS_W-1:0] refTs;
  logic            refSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTs   <= '0;
      refSeen <= 1'b0;
    end else if (strobe.clearAll) begin
      refTs   <= '0;
      refSeen <= 1'b0;
    end else if (strobe.refTake) begin
      refTs   <= stamp;
      refSeen <= 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [TS_W-1:0]          hitTs;
    logic                     hitSeen;
    logic signed [DIFF_W-1:0] diff;
    logic                     outOfRange;

    always_comb begin
      diff       = $signed({1'b0, hitTs}) - $signed({1'b0, refTs});
      outOfRange = (diff > LIM) || (diff < -LIM) || (hitTs == TS_MAX) || (refTs == TS_MAX);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitTs                     <= '0;
        hitSeen                   <= 1'b0;
        dataOut[ch*RES_W +: RES_W] <= '0;
        validOut[ch]              <= 1'b0;
      end else if (strobe.clearAll) begin
        hitTs                     <= '0;
        hitSeen                   <= 1'b0;
        dataOut[ch*RES_W +: RES_W] <= '0;
        validOut[ch]              <= 1'b0;
      end else begin
        if (hitTake[ch]) begin
          hitTs   <= stamp;
          hitSeen <= 1'b1;
        end
        if (hitSeen && refSeen) begin
          if (outOfRange) begin
            dataOut[ch*RES_W +: RES_W] <= diff[DIFF_W-1] ? NEG_SAT : POS_SAT;
            validOut[ch]              <= 1'b0;
          end else begin
            dataOut[ch*RES_W +: RES_W] <= diff[RES_W-1:0];
            validOut[ch]              <= 1'b1;
          end
        end else begin
          dataOut[ch*RES_W +: RES_W] <= '0;
          validOut[ch]              <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/signed_interval_counter.sv
module signed_interval_counter
  import tic_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAG_W  = 23
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH-1:0]           hitIn,
  input  logic                        refIn,
  input  logic                        hitVeto,
  input  logic                        refVeto,
  input  logic                        windowEnd,
  input  logic                        clearIn,
  output logic [NUM_CH*(MAG_W+1)-1:0] dataOut,
  output logic [NUM_CH-1:0]           validOut,
  output logic                        busy
);
  localparam int TS_W = MAG_W + 2;

  ctrlStrobe_t       strobe;
  logic [NUM_CH-1:0] hitTake;
  logic [TS_W-1:0]   stamp;

  tic_ctrl #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .refIn(refIn),
    .hitVeto(hitVeto), .refVeto(refVeto), .windowEnd(windowEnd), .clearIn(clearIn),
    .strobe(strobe), .hitTake(hitTake), .stamp(stamp), .busy(busy)
  );

  tic_datapath #(.NUM_CH(NUM_CH), .MAG_W(MAG_W), .TS_W(TS_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hitTake(hitTake), .stamp(stamp),
    .dataOut(dataOut), .validOut(validOut)
  );
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
  parameter int NUM_CH = 8,
  parameter int MAG_W  = 23
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_CH-1:0]           hitIn,
  input logic                        refIn,
  input logic                        hitVeto,
  input logic                        refVeto,
  input logic                        clearIn,
  input logic [NUM_CH*(MAG_W+1)-1:0] dataOut,
  input logic [NUM_CH-1:0]           validOut,
  input logic                        busy
);
  // R8: busy holds until a clear
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !clearIn) |=> busy);

  // R9: clear empties everything on the next edge
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (!busy && validOut == '0 && dataOut == '0));

  // R4: with no unvetoed input, an idle block stays idle
  p_veto_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (hitIn == '0 || hitVeto) && (!refIn || refVeto)) |=> !busy);

  // R6: a valid bit never drops without a clear
  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clearIn |=> ((validOut & $past(validOut)) == $past(validOut)));

  // R5: a valid result implies accepted edges, hence busy
  p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut != '0) |-> busy);
endmodule

bind signed_interval_counter tic_checker #(.NUM_CH(NUM_CH), .MAG_W(MAG_W)) u_tic_checker (
  .clk(clk), .rstN(rstN), .hitIn(hitIn), .refIn(refIn), .hitVeto(hitVeto),
  .refVeto(refVeto), .clearIn(clearIn), .dataOut(dataOut), .validOut(validOut), .busy(busy)
);

// File: tb/signed_interval_counter_bench.sv
module signed_interval_counter_bench;
  localparam int NUM_CH = 8;
  localparam int MAG_W  = 6;
  localparam int RES_W  = MAG_W + 1;
  localparam int LIM    = (2 ** MAG_W) - 1;
  localparam int NONE   = 255;

  // {ref, hit7 .. hit0}, cycle index within an 80-cycle window, 255 = absent
  localparam logic [71:0] VEC [4] = '{
    {8'd5,   8'd68, 8'd255, 8'd55, 8'd2,  8'd0,  8'd10, 8'd6,  8'd5},
    {8'd255, 8'd8,  8'd7,   8'd6,  8'd5,  8'd4,  8'd3,  8'd2,  8'd1},
    {8'd70,  8'd50, 8'd71,  8'd255,8'd79, 8'd70, 8'd7,  8'd6,  8'd0},
    {8'd0,   8'd6,  8'd5,   8'd4,  8'd3,  8'd2,  8'd1,  8'd63, 8'd64}
  };

  logic clk = 0, rstN = 0;
  logic [NUM_CH-1:0] hitIn = '0;
  logic refIn = 0, hitVeto = 0, refVeto = 0, windowEnd = 0, clearIn = 0;
  logic [NUM_CH*RES_W-1:0] dataOut;
  logic [NUM_CH-1:0] validOut;
  logic busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  signed_interval_counter #(.NUM_CH(NUM_CH), .MAG_W(MAG_W)) u_signed_interval_counter (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .refIn(refIn), .hitVeto(hitVeto),
    .refVeto(refVeto), .windowEnd(windowEnd), .clearIn(clearIn),
    .dataOut(dataOut), .validOut(validOut), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkChan(input string tag, input int ch, input int expData, input int expValid);
    chk({tag, $sformatf(" ch%0d data", ch)}, int'(dataOut[ch*RES_W +: RES_W]), expData & ((1 << RES_W) - 1));
    chk({tag, $sformatf(" ch%0d valid", ch)}, int'(validOut[ch]), expValid);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doClear();
    tick(); clearIn = 1;
    tick(); clearIn = 0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // reset state
    chk("R9 reset busy", int'(busy), 0);
    chk("R5 reset valid", int'(validOut), 0);
    chk("R9 reset data", int'(dataOut != '0), 0);

    // table of windows
    foreach (VEC[v]) begin
      int refAt;
      refAt = int'(VEC[v][71:64]);
      doClear();
      for (int t = 0; t < 80; t++) begin
        tick();
        refIn = (refAt == t);
        for (int i = 0; i < NUM_CH; i++) hitIn[i] = (int'(VEC[v][i*8 +: 8]) == t);
      end
      tick(); refIn = 0; hitIn = '0;
      tick();
      for (int i = 0; i < NUM_CH; i++) begin
        int h, d, ev;
        h = int'(VEC[v][i*8 +: 8]);
        if (h == NONE || refAt == NONE) begin d = 0; ev = 0; end   // R5
        else begin
          d = h - refAt; ev = 1;                                    // R1 R2 R3
          if (d > LIM) begin d = LIM; ev = 0; end                   // R10
          else if (d < -LIM) begin d = -LIM; ev = 0; end
        end
        chkChan($sformatf("R1/R2/R3/R5/R10 vec%0d", v), i, d, ev);
      end
    end

    // R8 busy timing and hold; R5 hit without reference
    doClear();
    chk("R8 idle busy", int'(busy), 0);
    hitIn[3] = 1;
    chk("R8 busy before edge", int'(busy), 0);
    tick(); hitIn[3] = 0;
    chk("R8 busy after edge", int'(busy), 1);
    repeat (20) tick();
    chk("R8 busy held", int'(busy), 1);
    chkChan("R5 no reference", 3, 0, 0);
    doClear();
    chk("R9 clear busy", int'(busy), 0);
    chk("R9 clear valid", int'(validOut), 0);

    // R4 vetoed edges set nothing
    doClear();
    tick(); hitVeto = 1; refVeto = 1; hitIn = '1; refIn = 1;
    tick(); hitIn = '0; refIn = 0;
    tick(); hitVeto = 0; refVeto = 0;
    tick();
    chk("R4 vetoed busy", int'(busy), 0);
    // vetoed reference, then accepted one; vetoed hit, then accepted one
    refVeto = 1; refIn = 1;
    tick(); refIn = 0; refVeto = 0;
    tick();
    tick(); refIn = 1;
    tick(); refIn = 0; hitVeto = 1; hitIn[0] = 1;
    tick(); hitIn[0] = 0; hitVeto = 0;
    tick(); hitIn[0] = 1; hitIn[1] = 1;
    tick(); hitIn = '0;
    tick();
    chkChan("R4 hit veto", 0, 3, 1);
    chkChan("R4 ref veto", 1, 3, 1);

    // R11 latency
    doClear();
    tick(); refIn = 1;
    tick(); refIn = 0;
    tick();
    tick(); hitIn[0] = 1;
    tick(); hitIn[0] = 0;
    chk("R11 not on accepting edge", int'(validOut[0]), 0);
    tick();
    chkChan("R11 next edge", 0, 3, 1);

    // R6 only first hit counts
    doClear();
    tick(); refIn = 1;
    tick(); refIn = 0; hitIn[2] = 1;
    tick(); hitIn[2] = 0;
    tick(); hitIn[2] = 1;
    tick(); hitIn[2] = 0;
    tick();
    chkChan("R6 first hit", 2, 1, 1);

    // R7 window end
    doClear();
    tick(); refIn = 1;
    tick(); refIn = 0;
    tick(); hitIn[0] = 1;
    tick(); hitIn[0] = 0; windowEnd = 1;
    tick(); windowEnd = 0; hitIn[1] = 1;
    tick(); hitIn = '0;
    tick();
    chkChan("R7 before window end", 0, 2, 1);
    chkChan("R7 after window end", 1, 0, 0);
    doClear();
    chk("R9 final clear data", int'(dataOut != '0), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule